// File: doc/BRIEF.md
# Flexible Second-Operand Shifter

This block forms the second operand of a data-processing instruction. It takes the low twelve bits of the instruction word and the immediate-select bit. In immediate form, it rotates an 8-bit constant right. In register form, it shifts an already-read register value by an amount of one of two kinds: a 5-bit constant taken from the instruction, or the bottom byte of a second, already-read register. It returns a 32-bit operand and the shifter carry-out that the ALU needs for its C flag. The current C flag arrives as an input.

The shifting logic is purely combinational. Its result passes through one output register with a valid/ready handshake, so the block sits in a streaming datapath. A request is taken on a cycle where `in_valid` and `in_ready` are both high. The result appears on the next cycle with `out_valid` high. `in_ready` is high whenever the output register is empty or is being drained that cycle. While `out_valid` is high and `out_ready` is low, the output register holds its data and `in_ready` stays low.

Top module: `shf_operand2`

## Requirements
- R1: A request accepted on a clock edge (`in_valid` and `in_ready` both high) shows up on `op2`/`c_out` with `out_valid` high one cycle later. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `op2`, `c_out` and `out_valid` hold their values.
- R2: After reset, `out_valid` is low and `in_ready` is high.
- R3: With `imm_sel` = 1, `op2` is `instr_lo[7:0]` zero-extended and rotated right by 2 × `instr_lo[11:8]`. `c_out` is `op2[31]` when that rotation is nonzero and `c_in` when it is zero.
- R4: With `imm_sel` = 0, `instr_lo[6:5]` picks the shift: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. `instr_lo[4]` = 0 takes the amount from `instr_lo[11:7]`. `instr_lo[4]` = 1 takes it from `rs_val`.
- R5: A logical left shift by n = 1..31 fills with zeros, and `c_out` is `rm_val[32-n]`. An immediate amount of 0 passes `rm_val` through, with `c_out` = `c_in`.
- R6: A logical right shift by n = 1..31 fills with zeros, and `c_out` is `rm_val[n-1]`. An immediate amount of 0 means a shift by 32: the result is 0 and `c_out` is `rm_val[31]`.
- R7: An arithmetic right shift fills with copies of `rm_val[31]`, and `c_out` is `rm_val[n-1]`. An immediate amount of 0 means a shift by 32: every bit of the result is `rm_val[31]`, and so is `c_out`.
- R8: A rotate right by a nonzero immediate amount gives `c_out` = `op2[31]`. An immediate amount of 0 is the extended rotate: the result is `{c_in, rm_val[31:1]}` and `c_out` is `rm_val[0]`.
- R9: With a register amount of 0, `op2` = `rm_val` and `c_out` = `c_in`, whatever the shift type.
- R10: Register amounts of 32 or more behave as follows:
  - logical left by exactly 32 gives 0, with `c_out` = `rm_val[0]`;
  - logical right by exactly 32 gives 0, with `c_out` = `rm_val[31]`;
  - logical shifts above 32 give 0, with `c_out` = 0;
  - arithmetic right by 32 or more gives all sign bits, with `c_out` = `rm_val[31]`;
  - rotate right uses the amount modulo 32, and a nonzero multiple of 32 gives `rm_val` with `c_out` = `rm_val[31]`.
- R11: Only `rs_val[7:0]` sets a register amount; `rs_val[31:8]` has no effect on `op2` or `c_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| imm_sel | input | 1 | 1 = immediate form, 0 = register form |
| instr_lo | input | 12 | Low twelve instruction bits (operand field) |
| rm_val | input | 32 | Value of the shifted register |
| rs_val | input | 32 | Value of the amount register |
| c_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| op2 | output | 32 | Formed second operand |
| c_out | output | 1 | Shifter carry-out |

## Verification
Some behaviours are checked on every cycle by the assertions:
- output hold under back-pressure and acceptance latency;
- pass-through for immediate zero rotation, logical-left by zero and a register amount of zero;
- the extended rotate;
- the sign fill of large arithmetic shifts;
- the rule that a nonzero immediate rotation carries out bit 31 of the result.

Exact values for every type and amount, and the carry bit index for shifts between 1 and 31, are shown only by the bench scenarios. The same holds for the cutoffs at 32 and above 32, and for the independence from the upper bits of `rs_val`. The bench compares each of these against a bit-serial model.

// File: rtl/shf_pkg.sv
package shf_pkg;
  localparam int DATA_W  = 32;
  localparam int IMM_W   = 8;
  localparam int ROT_W   = 4;
  localparam int SAMT_W  = 5;
  localparam int RAMT_W  = 8;
  localparam int FIELD_W = 12;
  localparam int CNT_W   = $clog2(DATA_W) + 1;

  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;

  typedef struct packed {
    logic              carry;
    logic [DATA_W-1:0] value;
  } shf_res_t;
endpackage

// File: rtl/shf_imm_rotator.sv
module shf_imm_rotator
  import shf_pkg::*;
(
  input  logic [FIELD_W-1:0] field,
  input  logic               c_in,
  output shf_res_t           res
);
  localparam int RAW_W = ROT_W + 1;

  logic [DATA_W-1:0] base;
  logic [RAW_W-1:0]  rot;
  logic [CNT_W-1:0]  back;
  logic [DATA_W-1:0] rotated;

  always_comb begin
    base    = {{(DATA_W-IMM_W){1'b0}}, field[IMM_W-1:0]};
    rot     = {field[IMM_W+ROT_W-1:IMM_W], 1'b0};
    back    = CNT_W'(DATA_W) - CNT_W'(rot);
    rotated = (base >> rot) | (base << back);
    res.value = rotated;
    res.carry = (rot == '0) ? c_in : rotated[DATA_W-1];
  end
endmodule

// File: rtl/shf_amt_decode.sv
module shf_amt_decode
  import shf_pkg::*;
(
  input  logic [FIELD_W-1:4] field,
  input  logic [RAMT_W-1:0]  rs_byte,
  output shift_kind_e        kind,
  output logic [RAMT_W-1:0]  amount,
  output logic               pass,
  output logic               rrx
);
  logic [SAMT_W-1:0] imm_amt;

  always_comb begin
    kind    = shift_kind_e'(field[6:5]);
    imm_amt = field[11:7];
    amount  = '0;
    pass    = 1'b0;
    rrx     = 1'b0;
    if (field[4]) begin
      amount = rs_byte;
      pass   = (rs_byte == '0);
    end else if (imm_amt != '0) begin
      amount = RAMT_W'(imm_amt);
    end else begin
      case (kind)
        SK_LSL:         pass   = 1'b1;
        SK_LSR, SK_ASR: amount = RAMT_W'(DATA_W);
        default:        rrx    = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/shf_reg_shifter.sv
module shf_reg_shifter
  import shf_pkg::*;
(
  input  logic [DATA_W-1:0] rm,
  input  logic              c_in,
  input  shift_kind_e       kind,
  input  logic [RAMT_W-1:0] amount,
  input  logic              pass,
  input  logic              rrx,
  output shf_res_t          res
);
  localparam int LOG_W = CNT_W - 1;

  logic [DATA_W:0]        lsl_w;
  logic [DATA_W:0]        lsr_w;
  logic signed [DATA_W:0] asr_src;
  logic signed [DATA_W:0] asr_w;
  logic [RAMT_W-1:0]      asr_amt;
  logic [LOG_W-1:0]       ror_amt;
  logic [CNT_W-1:0]       ror_back;
  logic [DATA_W-1:0]      ror_v;

  always_comb begin
    lsl_w    = {1'b0, rm} << amount;
    lsr_w    = {rm, 1'b0} >> amount;
    asr_amt  = (amount > RAMT_W'(DATA_W)) ? RAMT_W'(DATA_W) : amount;
    asr_src  = {rm, 1'b0};
    asr_w    = asr_src >>> asr_amt;
    ror_amt  = amount[LOG_W-1:0];
    ror_back = CNT_W'(DATA_W) - CNT_W'(ror_amt);
    ror_v    = (rm >> ror_amt) | (rm << ror_back);

    if (pass) begin
      res.value = rm;
      res.carry = c_in;
    end else if (rrx) begin
      res.value = {c_in, rm[DATA_W-1:1]};
      res.carry = rm[0];
    end else begin
      case (kind)
        SK_LSL: begin
          res.value = lsl_w[DATA_W-1:0];
          res.carry = lsl_w[DATA_W];
        end
        SK_LSR: begin
          res.value = lsr_w[DATA_W:1];
          res.carry = lsr_w[0];
        end
        SK_ASR: begin
          res.value = asr_w[DATA_W:1];
          res.carry = asr_w[0];
        end
        default: begin
          res.value = ror_v;
          res.carry = ror_v[DATA_W-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/shf_operand2.sv
module shf_operand2
  import shf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               imm_sel,
  input  logic [FIELD_W-1:0] instr_lo,
  input  logic [DATA_W-1:0]  rm_val,
  input  logic [DATA_W-1:0]  rs_val,
  input  logic               c_in,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  op2,
  output logic               c_out
);
  shf_res_t          imm_res;
  shf_res_t          reg_res;
  shf_res_t          sel_res;
  shf_res_t          held;
  shift_kind_e       kind;
  logic [RAMT_W-1:0] amount;
  logic              pass;
  logic              rrx;
  logic              unused_rs_hi;
  logic              take;

  assign unused_rs_hi = ^rs_val[DATA_W-1:RAMT_W];

  shf_imm_rotator imm_i (
    .field (instr_lo),
    .c_in  (c_in),
    .res   (imm_res)
  );

  shf_amt_decode dec_i (
    .field   (instr_lo[FIELD_W-1:4]),
    .rs_byte (rs_val[RAMT_W-1:0]),
    .kind    (kind),
    .amount  (amount),
    .pass    (pass),
    .rrx     (rrx)
  );

  shf_reg_shifter sh_i (
    .rm     (rm_val),
    .c_in   (c_in),
    .kind   (kind),
    .amount (amount),
    .pass   (pass),
    .rrx    (rrx),
    .res    (reg_res)
  );

  assign sel_res  = imm_sel ? imm_res : reg_res;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      held      <= '0;
    end else begin
      if (take) begin
        held      <= sel_res;
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign op2   = held.value;
  assign c_out = held.carry;
endmodule

// File: rtl/shf_operand2_chk.sv
module shf_operand2_chk
  import shf_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               imm_sel,
  input logic [FIELD_W-1:0] instr_lo,
  input logic [DATA_W-1:0]  rm_val,
  input logic [DATA_W-1:0]  rs_val,
  input logic               c_in,
  input logic               out_valid,
  input logic               out_ready,
  input logic [DATA_W-1:0]  op2,
  input logic               c_out
);
  logic acc;
  assign acc = in_valid && in_ready;

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(op2) && $stable(c_out)));

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  assert_imm_norot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && imm_sel && instr_lo[11:8] == 4'd0) |=>
      (op2 == {24'd0, $past(instr_lo[7:0])} && c_out == $past(c_in)));

  assert_imm_rot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && imm_sel && instr_lo[11:8] != 4'd0) |=>
      (c_out == op2[31] && $countones(op2) == $countones($past(instr_lo[7:0]))));

  assert_lsl_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !imm_sel && instr_lo[6:4] == 3'b000 && instr_lo[11:7] == 5'd0) |=>
      (op2 == $past(rm_val) && c_out == $past(c_in)));

  assert_rrx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !imm_sel && instr_lo[6:4] == 3'b110 && instr_lo[11:7] == 5'd0) |=>
      (op2 == {$past(c_in), $past(rm_val[31:1])} && c_out == $past(rm_val[0])));

  assert_regzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !imm_sel && instr_lo[4] && rs_val[7:0] == 8'd0) |=>
      (op2 == $past(rm_val) && c_out == $past(c_in)));

  assert_asr_big_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !imm_sel && instr_lo[6:4] == 3'b101 && rs_val[7:0] >= 8'd32) |=>
      (op2 == {32{c_out}} && c_out == $past(rm_val[31])));
endmodule

bind shf_operand2 shf_operand2_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .imm_sel   (imm_sel),
  .instr_lo  (instr_lo),
  .rm_val    (rm_val),
  .rs_val    (rs_val),
  .c_in      (c_in),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .op2       (op2),
  .c_out     (c_out)
);

// File: tb/shf_operand2_tb_top.sv
module shf_operand2_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic        imm_sel;
  logic [11:0] instr_lo;
  logic [31:0] rm_val;
  logic [31:0] rs_val;
  logic        c_in;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] op2;
  logic        c_out;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  shf_operand2 dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .imm_sel(imm_sel), .instr_lo(instr_lo), .rm_val(rm_val), .rs_val(rs_val),
    .c_in(c_in), .out_valid(out_valid), .out_ready(out_ready),
    .op2(op2), .c_out(c_out)
  );

  // Bit-serial model: {carry, value}
  function automatic logic [32:0] model(input logic immf, input logic [11:0] f,
                                        input logic [31:0] rm, input logic [31:0] rs,
                                        input logic c);
    logic [31:0] v;
    logic        cy;
    int          n;
    cy = c;
    if (immf) begin
      v = {24'd0, f[7:0]};
      n = 2 * int'(f[11:8]);
      for (int k = 0; k < n; k++) v = {v[0], v[31:1]};
      if (n != 0) cy = v[31];
      return {cy, v};
    end
    v = rm;
    if (!f[4]) begin
      n = int'(f[11:7]);
      if (n == 0) begin
        case (f[6:5])
          2'b00: return {c, rm};
          2'b11: return {rm[0], c, rm[31:1]};
          default: n = 32;
        endcase
      end
    end else begin
      n = int'(rs[7:0]);
    end
    for (int k = 0; k < n; k++) begin
      case (f[6:5])
        2'b00: begin cy = v[31]; v = {v[30:0], 1'b0}; end
        2'b01: begin cy = v[0];  v = {1'b0, v[31:1]}; end
        2'b10: begin cy = v[0];  v = {v[31], v[31:1]}; end
        default: begin cy = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    return {cy, v};
  endfunction

  function automatic string tag_of(input logic immf, input logic [11:0] f);
    if (immf) return "R3";
    case (f[6:5])
      2'b00: return "R5";
      2'b01: return "R6";
      2'b10: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [32:0] got, input logic [32:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got c=%0b v=%08h, expected c=%0b v=%08h",
               req, got[32], got[31:0], exp[32], exp[31:0]);
    end
  endtask

  task automatic check_bit(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0b, expected %0b", req, got, exp);
    end
  endtask

  // Drive one request with out_ready high; check one cycle later.
  task automatic run_one(input string req, input logic immf, input logic [11:0] f,
                         input logic [31:0] rm, input logic [31:0] rs, input logic c);
    @(negedge clk);
    imm_sel = immf; instr_lo = f; rm_val = rm; rs_val = rs; c_in = c;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit({req, " out_valid"}, out_valid, 1'b1);
    check(req, {c_out, op2}, model(immf, f, rm, rs, c));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [32:0] first;
    logic [31:0] rr, ss;
    logic [11:0] ff;
    logic        ii, cc;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    imm_sel = 1'b0; instr_lo = '0; rm_val = '0; rs_val = '0; c_in = 1'b0;
    repeat (3) @(negedge clk);
    check_bit("R2 out_valid", out_valid, 1'b0);
    check_bit("R2 in_ready", in_ready, 1'b1);
    rst_n = 1'b1;

    // Immediate form
    run_one("R3 rot0", 1'b1, 12'h0A5, 32'h0, 32'h0, 1'b1);
    run_one("R3 rot2", 1'b1, 12'h1FF, 32'h0, 32'h0, 1'b0);
    run_one("R3 rot30", 1'b1, 12'hF81, 32'h0, 32'h0, 1'b0);
    // Immediate amounts
    run_one("R5 lsl0", 1'b0, {5'd0, 2'b00, 1'b0, 4'd3}, 32'hDEADBEEF, 32'h0, 1'b1);
    run_one("R5 lsl1", 1'b0, {5'd1, 2'b00, 1'b0, 4'd3}, 32'h80000001, 32'h0, 1'b0);
    run_one("R5 lsl31", 1'b0, {5'd31, 2'b00, 1'b0, 4'd3}, 32'h00000003, 32'h0, 1'b0);
    run_one("R6 lsr0", 1'b0, {5'd0, 2'b01, 1'b0, 4'd3}, 32'h80000000, 32'h0, 1'b0);
    run_one("R6 lsr4", 1'b0, {5'd4, 2'b01, 1'b0, 4'd3}, 32'hF000000F, 32'h0, 1'b0);
    run_one("R7 asr0", 1'b0, {5'd0, 2'b10, 1'b0, 4'd3}, 32'h80000000, 32'h0, 1'b0);
    run_one("R7 asr5", 1'b0, {5'd5, 2'b10, 1'b0, 4'd3}, 32'h80000010, 32'h0, 1'b0);
    run_one("R8 rrx", 1'b0, {5'd0, 2'b11, 1'b0, 4'd3}, 32'h00000003, 32'h0, 1'b1);
    run_one("R8 ror8", 1'b0, {5'd8, 2'b11, 1'b0, 4'd3}, 32'h123456FF, 32'h0, 1'b0);
    // Register amounts
    run_one("R4 regsel", 1'b0, {4'd2, 1'b0, 2'b00, 1'b1, 4'd1}, 32'h00000101, 32'd3, 1'b0);
    run_one("R9 lsl", 1'b0, {4'd2, 1'b0, 2'b00, 1'b1, 4'd1}, 32'hCAFEF00D, 32'h0, 1'b1);
    run_one("R9 ror", 1'b0, {4'd2, 1'b0, 2'b11, 1'b1, 4'd1}, 32'hCAFEF00D, 32'h0, 1'b0);
    run_one("R10 lsl32", 1'b0, {4'd2, 1'b0, 2'b00, 1'b1, 4'd1}, 32'h00000001, 32'd32, 1'b0);
    run_one("R10 lsl33", 1'b0, {4'd2, 1'b0, 2'b00, 1'b1, 4'd1}, 32'hFFFFFFFF, 32'd33, 1'b1);
    run_one("R10 lsr32", 1'b0, {4'd2, 1'b0, 2'b01, 1'b1, 4'd1}, 32'h80000000, 32'd32, 1'b0);
    run_one("R10 lsr200", 1'b0, {4'd2, 1'b0, 2'b01, 1'b1, 4'd1}, 32'hFFFFFFFF, 32'd200, 1'b1);
    run_one("R10 asr255", 1'b0, {4'd2, 1'b0, 2'b10, 1'b1, 4'd1}, 32'h80000000, 32'd255, 1'b0);
    run_one("R10 ror32", 1'b0, {4'd2, 1'b0, 2'b11, 1'b1, 4'd1}, 32'h80000001, 32'd32, 1'b0);
    run_one("R10 ror36", 1'b0, {4'd2, 1'b0, 2'b11, 1'b1, 4'd1}, 32'h0000000F, 32'd36, 1'b0);
    run_one("R11 rs_hi", 1'b0, {4'd2, 1'b0, 2'b01, 1'b1, 4'd1}, 32'hF0F0F0F0, 32'hFFFFFF04, 1'b0);
    run_one("R11 rs_hi0", 1'b0, {4'd2, 1'b0, 2'b00, 1'b1, 4'd1}, 32'h12345678, 32'hABCDEF00, 1'b1);

    // Back-pressure (R1)
    @(negedge clk);
    out_ready = 1'b0;
    imm_sel = 1'b1; instr_lo = 12'h2AB; rm_val = '0; rs_val = '0; c_in = 1'b0;
    in_valid = 1'b1;
    first = model(1'b1, 12'h2AB, '0, '0, 1'b0);
    @(negedge clk);
    check_bit("R1 in_ready stalled", in_ready, 1'b0);
    imm_sel = 1'b0; instr_lo = {5'd3, 2'b00, 1'b0, 4'd0}; rm_val = 32'h1; c_in = 1'b0;
    repeat (2) @(negedge clk);
    check_bit("R1 valid held", out_valid, 1'b1);
    check("R1 data held", {c_out, op2}, first);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 second item", {c_out, op2}, model(1'b0, {5'd3, 2'b00, 1'b0, 4'd0}, 32'h1, '0, 1'b0));
    @(negedge clk);
    check_bit("R1 drained", out_valid, 1'b0);

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      ii = ($urandom % 4) == 0;
      ff = 12'($urandom);
      rr = $urandom;
      case ($urandom % 4)
        0: ss = $urandom % 33;
        1: ss = 32'd32 + ($urandom % 8);
        2: ss = {24'($urandom), 8'd0};
        default: ss = $urandom;
      endcase
      if (ff[4]) ff[7] = 1'b0;
      cc = 1'($urandom);
      run_one(tag_of(ii, ff), ii, ff, rr, ss, cc);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule